// File: doc/BRIEF.md
# Keypad Matrix Row Sense Interface

This block connects a small register port to a keypad wired as a matrix of rows and columns. Software writes a column-drive register whose bits go straight to the column pads. A bit written as 0 pulls that column low and so selects it for sensing. The row pads come back active low. They pass through a two-flop synchronizer into a row latch that software reads. A row bit reads 0 when a pressed key on that row sits on a column that is currently driven low. Scanning is done by software: it writes one column pattern after another and reads the row latch after each. The block has no debouncing and no scan sequencer.

A keyboard interrupt level is derived from the row latch. The status bit is 1 whenever any row is active and the one-bit mask is clear. The interrupt pin is that status gated by a clock-enable input. While the clock-enable is low the row latch is frozen. The first clock edge with the enable high takes in the current synchronized rows again.

The register port is a plain single-cycle strobe. It never stalls and has no back-pressure. A write takes effect at the clock edge where it is presented. Read data comes back with a valid pulse one cycle after the request.

Top module: `kbd_matrix_if`

## Requirements
- R1: After reset the row latch reads 0x1F, the column-drive register and `col_drv_n` are all ones, the mask reads 0 and `kbd_irq` is low.
- R2: A write to offset 0x14 stores the low COLS data bits. They read back from 0x14 and appear on `col_drv_n` from the next cycle.
- R3: Offset 0x10 returns the row latch in bits [ROWS-1:0], with upper bits 0. A latch bit is the value of `row_in_n` seen through two synchronizer flops and one latch stage. It is therefore 0 when a pressed key on that row lies on a column driven 0.
- R4: Offset 0x20 returns in bit 0 a status that is 1 exactly when the row latch differs from all ones and the mask is 0. Its upper bits are 0.
- R5: A write to offset 0x28 stores only data bit 0 as the mask. Reads of 0x28 return that bit in bit 0 and zeros above it.
- R6: `kbd_irq` is high exactly when the status bit is 1 and `clk_on` is high.
- R7: While `clk_on` is low the row latch keeps its value. At the first clock edge with `clk_on` high it loads the current synchronized rows.
- R8: Writes to 0x10, to 0x20 and to unmapped offsets change no register. Reads of unmapped offsets return 0.
- R9: `bus_rvalid` pulses for one cycle in the cycle after a read request (`bus_sel` high, `bus_wr` low). `bus_rdata` holds the addressed value in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_on | input | 1 | Clock-enable qualifying row capture and interrupt |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after request |
| row_in_n | input | ROWS | Row sense pads, active low |
| col_drv_n | output | COLS | Column drive pads, 0 selects a column |
| kbd_irq | output | 1 | Keyboard interrupt level |

## Verification
The matrix is modelled in the bench as a pressed-key map combined with the driven columns. The vectors are chosen to tell apart cases that a wrong row equation would merge. One case is a pressed key with its column selected, and the same key with only a neighbouring column selected. Other cases are two keys on different rows with all columns selected, one of those keys isolated by a single column, and two keys sharing one column. The masked vector shows whether the status bit and the interrupt pin depend on the mask and not just on the row latch. A clock-enable drop with a key change behind it shows that the latch freezes and that it re-evaluates as soon as the enable returns. A further case checks that the interrupt pin is not merely a copy of the status bit.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam logic [7:0] OFS_ROWS = 8'h10;
  localparam logic [7:0] OFS_COLS = 8'h14;
  localparam logic [7:0] OFS_STAT = 8'h20;
  localparam logic [7:0] OFS_MASK = 8'h28;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ROWS,
    SEL_COLS,
    SEL_STAT,
    SEL_MASK
  } kbd_sel_e;

  function automatic kbd_sel_e kbd_decode(input logic [7:0] ofs);
    case (ofs)
      OFS_ROWS: kbd_decode = SEL_ROWS;
      OFS_COLS: kbd_decode = SEL_COLS;
      OFS_STAT: kbd_decode = SEL_STAT;
      OFS_MASK: kbd_decode = SEL_MASK;
      default:  kbd_decode = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/kbd_row_sync.sv
module kbd_row_sync #(
  parameter int ROWS   = 5,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_on,
  input  logic [ROWS-1:0] row_in_n,
  output logic [ROWS-1:0] row_latch
);
  localparam int LAST = STAGES - 1;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
      end else if (STAGES == 1) begin
        chain[0] <= row_in_n[r];
      end else begin
        chain <= {chain[STAGES-2:0], row_in_n[r]};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_latch[r] <= 1'b1;
      end else if (clk_on) begin
        row_latch[r] <= chain[LAST];
      end
    end
  end
endmodule

// File: rtl/kbd_irq_gen.sv
module kbd_irq_gen #(
  parameter int ROWS = 5
) (
  input  logic [ROWS-1:0] row_latch,
  input  logic            mask_q,
  input  logic            clk_on,
  output logic            status,
  output logic            kbd_irq
);
  logic any_row;

  always_comb begin
    any_row = ~&row_latch;
    status  = any_row & ~mask_q;
    kbd_irq = status & clk_on;
  end
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
  import kbd_pkg::*;
#(
  parameter int ROWS   = 5,
  parameter int COLS   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ROWS-1:0]   row_latch,
  input  logic              status,
  output logic [COLS-1:0]   col_q,
  output logic              mask_q,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  kbd_sel_e    sel;
  logic        hi_zero;
  logic        wr_en;
  logic        rd_en;
  logic [DATA_W-1:0] rd_next;
  logic        unused_wdata;

  always_comb begin
    hi_zero = 1'b1;
    if (ADDR_W > 8) hi_zero = (bus_addr >> 8) == '0;
    sel = hi_zero ? kbd_decode(bus_addr[7:0]) : SEL_NONE;
    wr_en = bus_sel & bus_wr;
    rd_en = bus_sel & ~bus_wr;
  end

  assign unused_wdata = ^bus_wdata[DATA_W-1:COLS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '1;
      mask_q <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        SEL_COLS: col_q  <= bus_wdata[COLS-1:0];
        SEL_MASK: mask_q <= bus_wdata[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_ROWS: rd_next[ROWS-1:0] = row_latch;
      SEL_COLS: rd_next[COLS-1:0] = col_q;
      SEL_STAT: rd_next[0]        = status;
      SEL_MASK: rd_next[0]        = mask_q;
      default:  rd_next           = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/kbd_matrix_if.sv
module kbd_matrix_if #(
  parameter int ROWS   = 5,
  parameter int COLS   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_on,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [ROWS-1:0]   row_in_n,
  output logic [COLS-1:0]   col_drv_n,
  output logic              kbd_irq
);
  logic [ROWS-1:0] row_latch;
  logic [COLS-1:0] col_q;
  logic            mask_q;
  logic            status;

  kbd_row_sync #(.ROWS(ROWS), .STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_on   (clk_on),
    .row_in_n (row_in_n),
    .row_latch(row_latch)
  );

  kbd_regs #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .row_latch (row_latch),
    .status    (status),
    .col_q     (col_q),
    .mask_q    (mask_q),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  kbd_irq_gen #(.ROWS(ROWS)) u_irq (
    .row_latch(row_latch),
    .mask_q   (mask_q),
    .clk_on   (clk_on),
    .status   (status),
    .kbd_irq  (kbd_irq)
  );

  assign col_drv_n = col_q;
endmodule

// File: rtl/kbd_matrix_if_chk.sv
module kbd_matrix_if_chk #(
  parameter int ROWS   = 5,
  parameter int COLS   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_on,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic [COLS-1:0]   col_drv_n,
  input logic              kbd_irq,
  input logic [ROWS-1:0]   row_latch,
  input logic              mask_q
);
  localparam logic [ADDR_W-1:0] A_COLS = ADDR_W'(kbd_pkg::OFS_COLS);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(kbd_pkg::OFS_MASK);

  // R1
  reset_cols_chk: assert property (@(posedge clk)
    !rst_n |=> (col_drv_n == '1 && row_latch == '1 && !mask_q));

  // R2
  col_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A_COLS) |=> col_drv_n == $past(bus_wdata[COLS-1:0]));

  // R5
  mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == A_MASK) |=> bus_rdata[DATA_W-1:1] == '0);

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_irq |-> clk_on);

  // R4
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_irq |-> (row_latch != '1 && !mask_q));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_on |=> $stable(row_latch));

  // R9
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  // R9
  rvalid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_sel && !bus_wr)) |=> !bus_rvalid);
endmodule

bind kbd_matrix_if kbd_matrix_if_chk #(
  .ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_on    (clk_on),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .col_drv_n (col_drv_n),
  .kbd_irq   (kbd_irq),
  .row_latch (row_latch),
  .mask_q    (mask_q)
);

// File: tb/kbd_matrix_if_tb.sv
module kbd_matrix_if_tb;
  localparam int ROWS = 5;
  localparam int COLS = 8;
  localparam int AW   = 8;
  localparam int DW   = 16;
  localparam int NVEC = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_on = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic [ROWS-1:0] row_in_n;
  logic [COLS-1:0] col_drv_n;
  logic          kbd_irq;
  logic [ROWS*COLS-1:0] press = '0;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] rd;

  always #10 clk = ~clk;

  always_comb begin
    for (int r = 0; r < ROWS; r++)
      row_in_n[r] = ~|(press[r*COLS +: COLS] & ~col_drv_n);
  end

  kbd_matrix_if u_dut (
    .clk(clk), .rst_n(rst_n), .clk_on(clk_on),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .row_in_n(row_in_n), .col_drv_n(col_drv_n), .kbd_irq(kbd_irq)
  );

  // {press, columns, mask, expected latch, expected irq}
  localparam logic [54:0] VEC [NVEC] = '{
    {40'h00_0000_0000, 8'h00, 1'b0, 5'h1F, 1'b0},
    {40'h00_0000_0001, 8'hFE, 1'b0, 5'h1E, 1'b1},
    {40'h00_0000_0001, 8'hFD, 1'b0, 5'h1F, 1'b0},
    {40'h80_0008_0000, 8'h00, 1'b0, 5'h0B, 1'b1},
    {40'h80_0008_0000, 8'h7F, 1'b1, 5'h0F, 1'b0},
    {40'h00_2000_2000, 8'hDF, 1'b0, 5'h15, 1'b1}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
    check("R9 rvalid", {15'd0, bus_rvalid}, 16'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 irq", {15'd0, kbd_irq}, 16'd0);
    check("R1 col pins", {8'd0, col_drv_n}, 16'h00FF);
    rdreg(8'h10, rd); check("R1 R3 latch", rd, 16'h001F);
    rdreg(8'h14, rd); check("R1 col reg", rd, 16'h00FF);
    rdreg(8'h28, rd); check("R1 mask", rd, 16'h0000);
    rdreg(8'h20, rd); check("R1 R4 status", rd, 16'h0000);

    // vector table: R2 R3 R4 R6
    for (int i = 0; i < NVEC; i++) begin
      press = VEC[i][54:15];
      wr(8'h14, {8'hA5, VEC[i][14:7]});
      check("R2 col pins", {8'd0, col_drv_n}, {8'd0, VEC[i][14:7]});
      wr(8'h28, {15'd0, VEC[i][6]});
      idle(4);
      rdreg(8'h10, rd); check("R3 latch", rd, {11'd0, VEC[i][5:1]});
      rdreg(8'h14, rd); check("R2 col read", rd, {8'd0, VEC[i][14:7]});
      rdreg(8'h20, rd); check("R4 status", rd, {15'd0, VEC[i][0]});
      check("R6 irq", {15'd0, kbd_irq}, {15'd0, VEC[i][0]});
    end

    // R7: latch frozen while clock-enable is low
    press = '0;
    wr(8'h28, 16'h0000);
    idle(4);
    clk_on = 1'b0;
    press = 40'h00_0000_0004;
    wr(8'h14, 16'h0000);
    idle(5);
    rdreg(8'h10, rd); check("R7 frozen latch", rd, 16'h001F);
    check("R6 irq gated", {15'd0, kbd_irq}, 16'd0);
    clk_on = 1'b1;
    @(negedge clk);
    check("R7 R6 irq on re-enable", {15'd0, kbd_irq}, 16'd1);
    rdreg(8'h10, rd); check("R7 latch reloaded", rd, 16'h001E);

    // R6: status alone does not raise irq with clock-enable low
    clk_on = 1'b0;
    @(negedge clk);
    check("R6 irq with enable low", {15'd0, kbd_irq}, 16'd0);
    rdreg(8'h20, rd); check("R4 status with enable low", rd, 16'h0001);
    clk_on = 1'b1;
    idle(1);

    // R8: read-only and unmapped writes ignored
    wr(8'h10, 16'h0000);
    wr(8'h20, 16'h0000);
    wr(8'h30, 16'h00FF);
    wr(8'h3C, 16'h0001);
    idle(4);
    rdreg(8'h10, rd); check("R8 latch unchanged", rd, 16'h001E);
    rdreg(8'h14, rd); check("R8 col unchanged", rd, 16'h0000);
    rdreg(8'h28, rd); check("R8 mask unchanged", rd, 16'h0000);
    rdreg(8'h30, rd); check("R8 unmapped read", rd, 16'h0000);
    check("R8 irq unchanged", {15'd0, kbd_irq}, 16'd1);

    // R5: mask keeps bit 0 only
    wr(8'h28, 16'hFFFE);
    rdreg(8'h28, rd); check("R5 mask bit0 clear", rd, 16'h0000);
    check("R5 irq unmasked", {15'd0, kbd_irq}, 16'd1);
    wr(8'h28, 16'h0003);
    rdreg(8'h28, rd); check("R5 mask read", rd, 16'h0001);
    check("R5 R6 irq masked", {15'd0, kbd_irq}, 16'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule